// File: doc/BRIEF.md
# Three-Dimensional Transfer Address Sequencer

This block steps through the source addresses of a transfer laid out in three dimensions: bytes form arrays, arrays form frames, and frames form a block. Software loads a start address, a signed array stride, a signed frame stride, an array count and a frame count, and picks one of two pacing modes. In per-array mode each synchronization event services one array. In per-frame mode each event services a whole frame. Between events the block presents the start address of the next array or frame to be serviced, so a data mover can read it directly.

The frame stride is applied differently in the two modes. In per-array mode it is added to the start of the last array of the frame that just ended. In per-frame mode it is added to the start of that frame's first array. All arithmetic is 32 bits wide and wraps. A load with a zero frame count or a zero array count is a null transfer. It produces no address, but it still reports completion. Completion is a one-cycle pulse, gated by an enable that is captured at load time.

Top module: `dma3d_addr_seq`

## Requirements
- R1: On the cycle after a load with nonzero frame and array counts, `addrValid` is 1, `curAddr` equals `cfgStart` and `donePulse` is 0.
- R2: In per-array mode (`cfgFrameMode`=0), a sync event that is not on the last array of a frame moves `curAddr` to the previous value plus the sign-extended array stride.
- R3: In per-array mode, a sync event on the last array of a frame that is not the last frame moves `curAddr` to that last array's start plus the sign-extended frame stride.
- R4: In per-frame mode (`cfgFrameMode`=1), every sync event except the last adds the sign-extended frame stride to the first-array address of the frame just serviced. The array count and the array stride play no part in this.
- R5: Both strides are 16-bit two's complement values, sign-extended to 32 bits. Address sums wrap modulo 2^32.
- R6: The sync event that services the final array (per-array mode) or final frame (per-frame mode) drops `addrValid` on the next cycle. When enabled, it also raises `donePulse` for exactly that one cycle.
- R7: A load with `cfgFrameCnt`=0 or `cfgArrayCnt`=0 leaves `addrValid` at 0. If enabled, it raises `donePulse` for the single cycle after the load.
- R8: When `cfgDoneEn` was 0 at load, `donePulse` stays 0 for that whole transfer, including null transfers.
- R9: A sync event while no transfer is active (after reset or after completion) changes neither `curAddr` nor `addrValid`, and it does not raise `donePulse`.
- R10: A load during an active transfer discards that transfer's progress and restarts from the new start address with all counters cleared. A load wins over a sync event in the same cycle.
- R11: After reset, `addrValid`=0, `donePulse`=0 and `curAddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture the configuration and start a transfer |
| cfgStart | input | 32 | Start byte address |
| cfgArrayIdx | input | 16 | Signed array stride |
| cfgFrameIdx | input | 16 | Signed frame stride |
| cfgArrayCnt | input | 16 | Arrays per frame |
| cfgFrameCnt | input | 16 | Frames per block |
| cfgFrameMode | input | 1 | 0 = one array per event, 1 = one frame per event |
| cfgDoneEn | input | 1 | Enable the completion pulse |
| syncEvt | input | 1 | Synchronization event |
| curAddr | output | 32 | Start address of the next array or frame |
| addrValid | output | 1 | `curAddr` is a live address |
| donePulse | output | 1 | One-cycle completion indication |

## Verification
The main risk is the anchor for the frame stride. If a design used the first array in per-array mode, or the last array in per-frame mode, every address after the first frame would be off by (count-1) array strides. The bench therefore runs both modes with several arrays per frame and compares every address against a closed-form position formula.

A negative frame stride and a start near the top of the address space expose a design that zero-extends or saturates instead of wrapping. Zero frame counts, a cleared completion enable, syncs after completion and a reload in the middle of a transfer show the remaining faults. These are a missing or doubled pulse, a stray address, or stale counters that end the restarted transfer too early.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

  typedef enum logic {
    MODE_PER_ARRAY = 1'b0,
    MODE_PER_FRAME = 1'b1
  } syncMode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } seqState_e;

  // strobes from control to datapath; at most one high per cycle
  typedef struct packed {
    logic loadAddr;
    logic stepArray;
    logic stepFrame;
  } stepStrobes_t;

endpackage

// File: rtl/dma3d_seq_ctrl.sv
module dma3d_seq_ctrl
  import dma3d_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         syncEvt,
  input  logic [CNT_W-1:0] cfgArrayCnt,
  input  logic [CNT_W-1:0] cfgFrameCnt,
  input  syncMode_e    cfgMode,
  input  logic         cfgDoneEn,
  output stepStrobes_t strobes,
  output logic         addrValid,
  output logic         donePulse
);

  seqState_e state, stateNxt;
  syncMode_e modeReg;
  logic      doneEnReg;
  logic [CNT_W-1:0] lastArr, lastFrm;
  logic [CNT_W-1:0] arrPos, frmPos;

  logic isNull, acceptSync, frameEnd, lastFrame, finish;

  assign isNull     = (cfgFrameCnt == '0) || (cfgArrayCnt == '0);
  assign acceptSync = syncEvt && !load && (state == ST_ACTIVE);
  assign frameEnd   = (modeReg == MODE_PER_FRAME) || (arrPos == lastArr);
  assign lastFrame  = (frmPos == lastFrm);
  assign finish     = acceptSync && frameEnd && lastFrame;

  always_comb begin
    strobes           = '0;
    strobes.loadAddr  = load;
    strobes.stepArray = acceptSync && !frameEnd;
    strobes.stepFrame = acceptSync && frameEnd && !lastFrame;
  end

  always_comb begin
    stateNxt = state;
    if (load)        stateNxt = isNull ? ST_DONE : ST_ACTIVE;
    else if (finish) stateNxt = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      modeReg   <= MODE_PER_ARRAY;
      doneEnReg <= 1'b0;
      lastArr   <= '0;
      lastFrm   <= '0;
      arrPos    <= '0;
      frmPos    <= '0;
      donePulse <= 1'b0;
    end else begin
      state     <= stateNxt;
      donePulse <= 1'b0;
      if (load) begin
        modeReg   <= cfgMode;
        doneEnReg <= cfgDoneEn;
        lastArr   <= cfgArrayCnt - 1'b1;
        lastFrm   <= cfgFrameCnt - 1'b1;
        arrPos    <= '0;
        frmPos    <= '0;
        donePulse <= isNull && cfgDoneEn;
      end else if (acceptSync) begin
        if (!frameEnd) begin
          arrPos <= arrPos + 1'b1;
        end else if (!lastFrame) begin
          arrPos <= '0;
          frmPos <= frmPos + 1'b1;
        end else begin
          donePulse <= doneEnReg;
        end
      end
    end
  end

  assign addrValid = (state == ST_ACTIVE);

  // completion indication never lasts two cycles without a reload
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse && !load |=> !donePulse);

  // no pulse when the captured enable is low
  p_done_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |-> doneEnReg);

  // a pulse can only follow a load or the final sync
  p_no_early_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid && !syncEvt && !load |=> !donePulse);

  // syncs outside an active transfer change nothing
  p_sync_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !addrValid && syncEvt && !load |=> !addrValid && !donePulse);

  // a real load always yields a live address and no pulse
  p_load_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load && !isNull |=> addrValid && !donePulse);

  // position counters stay inside the loaded bounds
  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid |-> (arrPos <= lastArr) && (frmPos <= lastFrm));

endmodule

// File: rtl/dma3d_seq_datapath.sv
module dma3d_seq_datapath
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfgStart,
  input  logic [IDX_W-1:0]  cfgArrayIdx,
  input  logic [IDX_W-1:0]  cfgFrameIdx,
  input  stepStrobes_t      strobes,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int EXT_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] arrStride, frmStride;
  logic [ADDR_W-1:0] addend;

  // one shared adder; the strobe picks the stride
  assign addend = strobes.stepFrame ? frmStride : arrStride;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr   <= '0;
      arrStride <= '0;
      frmStride <= '0;
    end else if (strobes.loadAddr) begin
      curAddr   <= cfgStart;
      arrStride <= {{EXT_W{cfgArrayIdx[IDX_W-1]}}, cfgArrayIdx};
      frmStride <= {{EXT_W{cfgFrameIdx[IDX_W-1]}}, cfgFrameIdx};
    end else if (strobes.stepArray || strobes.stepFrame) begin
      curAddr <= curAddr + addend;
    end
  end

  // control never requests two moves in one cycle
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.loadAddr, strobes.stepArray, strobes.stepFrame}));

  // without a strobe the address holds
  p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.loadAddr && !strobes.stepArray && !strobes.stepFrame |=> $stable(curAddr));

endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] cfgStart,
  input  logic [IDX_W-1:0]  cfgArrayIdx,
  input  logic [IDX_W-1:0]  cfgFrameIdx,
  input  logic [CNT_W-1:0]  cfgArrayCnt,
  input  logic [CNT_W-1:0]  cfgFrameCnt,
  input  logic              cfgFrameMode,
  input  logic              cfgDoneEn,
  input  logic              syncEvt,
  output logic [ADDR_W-1:0] curAddr,
  output logic              addrValid,
  output logic              donePulse
);

  stepStrobes_t strobes;

  dma3d_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .syncEvt     (syncEvt),
    .cfgArrayCnt (cfgArrayCnt),
    .cfgFrameCnt (cfgFrameCnt),
    .cfgMode     (syncMode_e'(cfgFrameMode)),
    .cfgDoneEn   (cfgDoneEn),
    .strobes     (strobes),
    .addrValid   (addrValid),
    .donePulse   (donePulse)
  );

  dma3d_seq_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgStart    (cfgStart),
    .cfgArrayIdx (cfgArrayIdx),
    .cfgFrameIdx (cfgFrameIdx),
    .strobes     (strobes),
    .curAddr     (curAddr)
  );

endmodule

// File: tb/dma3d_addr_seq_tb.sv
module dma3d_addr_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] cfgStart = '0;
  logic [15:0] cfgArrayIdx = '0, cfgFrameIdx = '0;
  logic [15:0] cfgArrayCnt = '0, cfgFrameCnt = '0;
  logic        cfgFrameMode = 1'b0, cfgDoneEn = 1'b0;
  logic        syncEvt = 1'b0;
  logic [31:0] curAddr;
  logic        addrValid, donePulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma3d_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .cfgStart(cfgStart),
    .cfgArrayIdx(cfgArrayIdx), .cfgFrameIdx(cfgFrameIdx),
    .cfgArrayCnt(cfgArrayCnt), .cfgFrameCnt(cfgFrameCnt),
    .cfgFrameMode(cfgFrameMode), .cfgDoneEn(cfgDoneEn), .syncEvt(syncEvt),
    .curAddr(curAddr), .addrValid(addrValid), .donePulse(donePulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // closed-form address of array a in frame f
  function automatic logic [31:0] expAddr(input bit perFrame, input logic [31:0] start,
      input logic [15:0] aIdx, input logic [15:0] fIdx, input int aCnt,
      input int f, input int a);
    logic [31:0] fStep;
    if (perFrame) fStep = sext(fIdx);
    else          fStep = 32'(aCnt - 1) * sext(aIdx) + sext(fIdx);
    return start + 32'(f) * fStep + 32'(a) * sext(aIdx);
  endfunction

  task automatic doLoad(input bit perFrame, input logic [31:0] start,
      input logic [15:0] aIdx, input logic [15:0] fIdx,
      input int aCnt, input int fCnt, input bit en);
    @(negedge clk);
    cfgFrameMode = perFrame; cfgStart = start; cfgArrayIdx = aIdx;
    cfgFrameIdx = fIdx; cfgArrayCnt = 16'(aCnt); cfgFrameCnt = 16'(fCnt);
    cfgDoneEn = en; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic doSync();
    @(negedge clk);
    syncEvt = 1'b1;
    @(negedge clk);
    syncEvt = 1'b0;
  endtask

  // full transfer from load to completion, every address checked
  task automatic runXfer(input string req, input bit perFrame, input logic [31:0] start,
      input logic [15:0] aIdx, input logic [15:0] fIdx,
      input int aCnt, input int fCnt, input bit en);
    int total;
    doLoad(perFrame, start, aIdx, fIdx, aCnt, fCnt, en);
    check(addrValid === 1'b1 && curAddr === start && donePulse === 1'b0,
          {req, " R1 load"}, curAddr, start);
    total = perFrame ? fCnt : fCnt * aCnt;
    for (int k = 0; k < total; k++) begin
      doSync();
      if (k == total - 1) begin
        check(addrValid === 1'b0, {req, " R6 valid drop"}, 32'(addrValid), 32'd0);
        check(donePulse === en, {req, " R6/R8 done"}, 32'(donePulse), 32'(en));
      end else begin
        int f, a;
        logic [31:0] e;
        f = perFrame ? k + 1 : (k + 1) / aCnt;
        a = perFrame ? 0 : (k + 1) % aCnt;
        e = expAddr(perFrame, start, aIdx, fIdx, aCnt, f, a);
        check(addrValid === 1'b1 && curAddr === e && donePulse === 1'b0,
              {req, " step"}, curAddr, e);
      end
    end
    @(negedge clk);
    check(donePulse === 1'b0, {req, " R6 single pulse"}, 32'(donePulse), 32'd0);
  endtask

  task automatic testReset();
    check(addrValid === 1'b0 && donePulse === 1'b0 && curAddr === 32'd0,
          "R11 reset", curAddr, 32'd0);
  endtask

  task automatic testIdleSync();
    logic [31:0] held;
    held = curAddr;
    doSync();  // R9 sync while not active
    check(addrValid === 1'b0 && donePulse === 1'b0 && curAddr === held,
          "R9 idle sync", curAddr, held);
  endtask

  task automatic testNull();
    doLoad(1'b0, 32'h1000, 16'h4, 16'h8, 3, 0, 1'b1);  // R7 zero frames
    check(addrValid === 1'b0 && donePulse === 1'b1, "R7 null frames",
          {30'd0, addrValid, donePulse}, 32'd1);
    @(negedge clk);
    check(donePulse === 1'b0, "R7 null single pulse", 32'(donePulse), 32'd0);
    doLoad(1'b1, 32'h1000, 16'h4, 16'h8, 0, 2, 1'b1);  // R7 zero arrays
    check(addrValid === 1'b0 && donePulse === 1'b1, "R7 null arrays",
          {30'd0, addrValid, donePulse}, 32'd1);
    doLoad(1'b0, 32'h1000, 16'h4, 16'h8, 3, 0, 1'b0);  // R8 null disabled
    check(addrValid === 1'b0 && donePulse === 1'b0, "R8 null disabled",
          32'(donePulse), 32'd0);
  endtask

  task automatic testRestart();
    doLoad(1'b0, 32'h5000, 16'h10, 16'h40, 2, 2, 1'b1);
    doSync();
    doSync();
    check(curAddr === 32'h5050, "R10 pre-restart progress", curAddr, 32'h5050);
    // R10: load together with a sync; the load wins
    @(negedge clk);
    cfgStart = 32'h9000; load = 1'b1; syncEvt = 1'b1;
    @(negedge clk);
    load = 1'b0; syncEvt = 1'b0;
    check(addrValid === 1'b1 && curAddr === 32'h9000, "R10 restart addr",
          curAddr, 32'h9000);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] e;
      doSync();
      e = expAddr(1'b0, 32'h9000, 16'h10, 16'h40, 2, (k + 1) / 2, (k + 1) % 2);
      check(addrValid === 1'b1 && curAddr === e && donePulse === 1'b0,
            "R10 counters cleared", curAddr, e);
    end
    doSync();
    check(addrValid === 1'b0 && donePulse === 1'b1, "R10 restart completes",
          32'(donePulse), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testIdleSync();
    rst_n = 1'b1;
    @(negedge clk);
    testIdleSync();
    runXfer("R2/R3 per-array", 1'b0, 32'h0000_2000, 16'h0010, 16'h0100, 3, 2, 1'b1);
    runXfer("R5 negative frame stride", 1'b0, 32'h0000_8000, 16'h0020, 16'hFFC0, 4, 3, 1'b1);
    runXfer("R5 negative array stride", 1'b0, 32'h0000_0100, 16'hFFF0, 16'h0200, 3, 2, 1'b1);
    runXfer("R4 per-frame", 1'b1, 32'h0001_0000, 16'h0030, 16'h0200, 5, 4, 1'b1);
    runXfer("R5 wrap", 1'b1, 32'hFFFF_FFF0, 16'h0004, 16'h0020, 2, 3, 1'b1);
    runXfer("R8 disabled", 1'b0, 32'h0000_3000, 16'h0008, 16'h0080, 2, 2, 1'b0);
    runXfer("R6 single array", 1'b0, 32'h0000_4000, 16'h0008, 16'h0080, 1, 1, 1'b1);
    testIdleSync();  // R9 after completion
    testNull();
    testRestart();
    testIdleSync();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule